// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital front end of a 20-bit audio converter. It watches three slow inputs: a bit clock, a serial data line and an active-low latch strobe. It samples all three in one fast system clock domain. Each rising edge of the bit clock shifts one data bit into a 20-bit register, most significant bit first. Only the newest 20 bits are held, so any number of filler bits may come before a word.

When the latch strobe falls, the register contents are copied into a pending word. That word moves to the parallel output on the fourth rising bit-clock edge after the fall, and a one-cycle update strobe marks the change. The bit clock may stop between words. A pending word then waits for its four edges, however long the pause lasts. The block also watches the latch strobe. It must stay high for at least one bit-clock edge before each fall, and low for at least one edge before each rise. A breach sets a sticky violation flag.

Top module: `dac_word_rx`

## Requirements
- R1: A data bit is taken on each rising edge of the bit clock and shifted in most significant bit first, so the first of the last 20 bits lands in output bit 19.
- R2: Only the last 20 bits before the latch fall are kept; any number of earlier filler bits has no effect on the output word.
- R3: The word is captured when the latch strobe falls; bits shifted in after the fall do not alter that word.
- R4: The output word changes on the fourth rising bit-clock edge after the latch fall and holds its old value through the first three.
- R5: The update strobe is high for exactly one system cycle, in the cycle the output word takes its new value, and the output word never changes without it.
- R6: If the bit clock stops after the latch fall, the output holds its previous value until four rising edges have arrived.
- R7: A latch fall with no rising bit-clock edge since the previous latch rise sets the violation flag.
- R8: A latch rise with no rising bit-clock edge since the previous latch fall sets the violation flag.
- R9: The violation flag stays set until reset.
- R10: Reset clears the output word to 00000 hex, the update strobe to 0 and the violation flag to 0.
- R11: Words pass through unchanged as 20-bit two's complement codes: 7FFFF hex is positive full scale, 80000 hex is negative full scale and 00000 hex is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| latch_n_i | input | 1 | Latch strobe; a falling edge captures the word |
| word_o | output | 20 | Parallel output word, two's complement |
| update_o | output | 1 | One-cycle pulse when word_o takes a new value |
| le_viol_o | output | 1 | Sticky flag for a latch strobe width violation |

## Verification
Assertions check four things on every cycle. The update strobe lasts a single cycle. The output word moves only together with that strobe, and every update falls on a detected bit-clock rise. The violation flag is sticky and is set only in a cycle that follows a latch edge. The bench scenarios cover what a one-cycle property cannot. These are the exact edge count from latch fall to output change, the discarding of filler bits, the capture of the word at the fall, the behaviour when the bit clock stops, and which strobe timings should or should not raise the flag.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int unsigned WORD_W      = 20;
  localparam int unsigned DELAY_EDGES = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dwr_sync.sv
module dwr_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dwr_edge.sv
module dwr_edge #(
  parameter int unsigned W        = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/dwr_shift.sv
module dwr_shift #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr = sr_q;
endmodule

// File: rtl/dwr_load.sv
module dwr_load #(
  parameter int unsigned W     = 20,
  parameter int unsigned DELAY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_rise,
  input  logic         le_fall,
  input  logic [W-1:0] sr,
  output logic [W-1:0] word,
  output logic         upd
);
  localparam int unsigned CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic [W-1:0]     pend_q, pend_d;
  logic [W-1:0]     word_q, word_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             upd_q, upd_d;

  always_comb begin
    pend_d  = pend_q;
    word_d  = word_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    upd_d   = 1'b0;
    if (le_fall) begin
      pend_d  = sr;
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && bclk_rise) begin
      if (cnt_q == LAST) begin
        word_d  = pend_q;
        upd_d   = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      word_q  <= word_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      upd_q   <= upd_d;
    end
  end

  assign word = word_q;
  assign upd  = upd_q;
endmodule

// File: rtl/dwr_lechk.sv
module dwr_lechk (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_rise,
  input  logic le_fall,
  input  logic le_rise,
  output logic viol
);
  logic seen_q, seen_d;
  logic viol_q, viol_d;

  always_comb begin
    seen_d = seen_q;
    viol_d = viol_q;
    if (le_fall || le_rise) begin
      if (!seen_q) viol_d = 1'b1;
      seen_d = 1'b0;
    end else if (bclk_rise) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b1;
      viol_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      viol_q <= viol_d;
    end
  end

  assign viol = viol_q;
endmodule

// File: rtl/dac_word_rx.sv
module dac_word_rx #(
  parameter int unsigned WIDTH = dwr_pkg::WORD_W,
  parameter int unsigned DELAY = dwr_pkg::DELAY_EDGES,
  parameter int unsigned SYNC  = dwr_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             sdata_i,
  input  logic             latch_n_i,
  output logic [WIDTH-1:0] word_o,
  output logic             update_o,
  output logic             le_viol_o
);
  // input bit order inside the synchronizer: {data, latch, bclk}
  localparam logic [2:0] SYNC_RST = 3'b010;
  localparam logic [1:0] EDGE_RST = 2'b10;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [2:0]       syn;
  logic [1:0]       chg;
  logic             bclk_rise, le_fall, le_rise;
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dwr_sync #(.W(3), .STAGES(SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sdata_i, latch_n_i, bclk_i}),
    .q     (syn)
  );

  dwr_edge #(.W(2), .RST_VAL(EDGE_RST)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (syn[1:0]),
    .chg   (chg)
  );

  assign bclk_rise = chg[0] &  syn[0];
  assign le_fall   = chg[1] & ~syn[1];
  assign le_rise   = chg[1] &  syn[1];

  dwr_shift #(.W(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (bclk_rise),
    .din      (syn[2]),
    .sr       (sr)
  );

  dwr_load #(.W(WIDTH), .DELAY(DELAY)) u_load (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bclk_rise (bclk_rise),
    .le_fall   (le_fall),
    .sr        (sr),
    .word      (word_o),
    .upd       (update_o)
  );

  dwr_lechk u_lechk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bclk_rise (bclk_rise),
    .le_fall   (le_fall),
    .le_rise   (le_rise),
    .viol      (le_viol_o)
  );
endmodule

// File: rtl/dac_word_rx_chk.sv
module dac_word_rx_chk #(
  parameter int unsigned WIDTH = dwr_pkg::WORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_rise,
  input logic             le_fall,
  input logic             le_rise,
  input logic [WIDTH-1:0] word_o,
  input logic             update_o,
  input logic             le_viol_o
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  p_word_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(word_o));

  p_update_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> $past(bclk_rise));

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    le_viol_o |=> le_viol_o);

  // R7 and R8: flag only rises right after a latch edge
  p_viol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_viol_o) |-> $past(le_fall || le_rise));
endmodule

bind dac_word_rx dac_word_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bclk_rise (bclk_rise),
  .le_fall   (le_fall),
  .le_rise   (le_rise),
  .word_o    (word_o),
  .update_o  (update_o),
  .le_viol_o (le_viol_o)
);

// File: tb/dac_word_rx_tb.sv
module dac_word_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, sdata, le;
  logic [19:0] word_o;
  logic        update_o, le_viol_o;

  int n_cmp = 0;
  int n_bad = 0;
  int upd_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_word_rx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk),
    .sdata_i   (sdata),
    .latch_n_i (le),
    .word_o    (word_o),
    .update_o  (update_o),
    .le_viol_o (le_viol_o)
  );

  always @(negedge clk) if (rst_n && update_o) upd_cnt++;

  // {filler bit count, word}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {8'd0,  20'h7FFFF},
    {8'd3,  20'h80000},
    {8'd7,  20'h00000},
    {8'd1,  20'hA5A5A},
    {8'd12, 20'h5A5A5},
    {8'd24, 20'h12345}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic b);
    bclk = 1'b0; sdata = b; waitn(4);
    bclk = 1'b1; waitn(4);
  endtask

  task automatic send_word(input logic [19:0] w, input int lead);
    for (int i = 0; i < lead; i++) tick(i[0] ^ 1'b1);
    for (int i = 19; i >= 0; i--) tick(w[i]);
  endtask

  // latch fall then four edges; checks hold through three, update on fourth
  task automatic latch_word(input logic [19:0] w, input logic [19:0] prev, input string req);
    int u0;
    le = 1'b0; waitn(4);
    tick(1'b1);
    le = 1'b1;
    tick(1'b0);
    tick(1'b1);
    chk({req, " R4 hold before 4th edge"}, {12'd0, word_o}, {12'd0, prev});
    u0 = upd_cnt;
    tick(1'b0);
    chk({req, " R4 update on 4th edge"}, {12'd0, word_o}, {12'd0, w});
    chk({req, " R5 one strobe"}, upd_cnt, u0 + 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; waitn(3);
    rst_n = 1'b1; waitn(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] prev;
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0; le = 1'b1;
    waitn(5);
    rst_n = 1'b1; waitn(4);
    chk("R10 word after reset", {12'd0, word_o}, 32'd0);
    chk("R10 strobe after reset", {31'd0, update_o}, 32'd0);
    chk("R10 flag after reset", {31'd0, le_viol_o}, 32'd0);

    // R1 R2 R3 R11: table of words with filler bits
    prev = '0;
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v][19:0], int'(VEC[v][27:20]));
      latch_word(VEC[v][19:0], prev, "R1 R2 R3 R11 vector");
      prev = VEC[v][19:0];
    end
    chk("R7 R8 no flag for legal timing", {31'd0, le_viol_o}, 32'd0);

    // R6: bit clock stops after latch fall
    send_word(20'h3C3C3, 2);
    le = 1'b0; waitn(60);
    chk("R6 held while clock stopped", {12'd0, word_o}, {12'd0, prev});
    tick(1'b0); le = 1'b1; waitn(40);
    tick(1'b1); tick(1'b0);
    chk("R6 held after three edges", {12'd0, word_o}, {12'd0, prev});
    tick(1'b1);
    chk("R6 update after fourth edge", {12'd0, word_o}, 32'h3C3C3);
    // R3: bits shifted after fall were 0,1,0,1; word must still be the latched one
    chk("R3 later bits not captured", {12'd0, word_o}, 32'h3C3C3);

    // R7: latch falls again with no edge since its rise
    tick(1'b0);
    le = 1'b0; waitn(4); tick(1'b0);
    le = 1'b1; waitn(4);
    chk("R7 no flag yet", {31'd0, le_viol_o}, 32'd0);
    le = 1'b0; waitn(6);
    chk("R7 short high flagged", {31'd0, le_viol_o}, 32'd1);
    tick(1'b0); le = 1'b1; tick(1'b0); tick(1'b0); tick(1'b0);
    chk("R9 flag stays set", {31'd0, le_viol_o}, 32'd1);

    // R10: reset mid run
    do_reset();
    chk("R10 flag cleared", {31'd0, le_viol_o}, 32'd0);
    chk("R10 word cleared", {12'd0, word_o}, 32'd0);

    // R8: latch rises with no edge since its fall
    tick(1'b0);
    le = 1'b0; waitn(6);
    chk("R8 no flag yet", {31'd0, le_viol_o}, 32'd0);
    le = 1'b1; waitn(6);
    chk("R8 short low flagged", {31'd0, le_viol_o}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule